// File: doc/BRIEF.md
# Selectable Clock Divider with Grouped Output Enables

This block conditions a clock for fan-out. It takes two candidate clocks and picks one with a select bit. The chosen clock can pass straight through or be divided by 2, 3 or 4. The result goes to four outputs that are copies of one another. Each output also has an enable flag, so that a tri-state pad can be modelled around it.

The outputs form two enable groups. The solo group holds output 0 alone, and the rest group holds outputs 1 to 3. Each group can be switched off without affecting the other. All controls may change while the clocks run, and no change ever produces a shortened pulse.

Source changes go through a break-before-make handover, where each side is synchronized to its own clock. Ratio changes are synchronized into the divided domain and take effect only when the divide counter wraps. Enable changes are applied on a falling edge at which the divided clock is about to stay low.

Top module: `clk_div_fanout`

## Requirements
- R1: With `src_sel`=1 the outputs follow `clk_diff`; with `src_sel`=0 they follow `clk_se`.
- R2: `div_sel` sets the ratio N = `div_sel`+1: code 0 gives /1, 1 gives /2, 2 gives /3 and 3 gives /4. Each enabled output makes one rising edge per N rising edges of the selected source.
- R3: For /2, /3 and /4 every enabled output is high for 45–55% of its period. For /3 this is reached by adding half a source cycle to the high phase.
- R4: At /1 the enabled outputs reproduce the selected source, with its frequency and its duty cycle.
- R5: `oe_solo` enables output 0 only, and `oe_rest` enables outputs 1, 2 and 3 only.
- R6: A disabled output holds its clock low and its `clk_oe` bit at 0. An enabled output has its `clk_oe` bit at 1.
- R7: Any two enabled outputs carry the same waveform at every instant.
- R8: Changing the source, the ratio or an enable never produces a high or low pulse on an output shorter than half a period of the faster source.
- R9: While `rst_n` is low, all `clk_out` and `clk_oe` bits are 0.
- R10: If all controls are held at 1 (their undriven level) through and after reset, the block runs from `clk_diff` at /4 with all four outputs enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_se | input | 1 | Single-ended candidate clock, chosen when `src_sel`=0 |
| clk_diff | input | 1 | Candidate clock taken from a differential receiver, chosen when `src_sel`=1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source select |
| div_sel | input | 2 | Ratio code, N = code+1 |
| oe_solo | input | 1 | Enable for output 0 |
| oe_rest | input | 1 | Enable for outputs 1 to 3 |
| clk_out | output | 4 | Divided clocks, held low when disabled |
| clk_oe | output | 4 | Per-output enable flags for the pads |

## Verification
The bench builds the block with its defaults: four outputs, a solo group of one, and two-stage synchronizers. This small configuration lets it sweep all eight combinations of source and ratio, and all four enable patterns. Frequency is checked by counting edges and duty by sampling levels, both against a window of 576 ns, which is a whole number of periods for every combination. A separate stress phase keeps changing the ratio, the source and the enables while it records the shortest pulse seen on the outputs.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] ratio_code_t;

  // high-phase length in source cycles (posedge part) for code c: (c+1)/2
  function automatic logic [SEL_W:0] high_span(input ratio_code_t c);
    logic [SEL_W:0] n;
    n = {1'b0, c} + 1'b1;
    return n >> 1;
  endfunction
endpackage

// File: rtl/cdiv_src_mux.sv
`timescale 1ns/1ps
module cdiv_src_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_se,
  input  logic clk_diff,
  input  logic rst_n,
  input  logic use_diff,
  output logic clk_sel
);
  logic [SYNC_STAGES-1:0] se_pipe, df_pipe;
  logic se_on, df_on, se_busy, df_busy;

  assign se_on   = se_pipe[SYNC_STAGES-1];
  assign df_on   = df_pipe[SYNC_STAGES-1];
  assign se_busy = |se_pipe;
  assign df_busy = |df_pipe;

  // each side only arms once the other side is fully drained
  always_ff @(negedge clk_se or negedge rst_n) begin
    if (!rst_n) se_pipe <= '0;
    else        se_pipe <= {se_pipe[SYNC_STAGES-2:0], ~use_diff & ~df_busy};
  end

  always_ff @(negedge clk_diff or negedge rst_n) begin
    if (!rst_n) df_pipe <= '0;
    else        df_pipe <= {df_pipe[SYNC_STAGES-2:0], use_diff & ~se_busy};
  end

  assign clk_sel = (clk_se & se_on) | (clk_diff & df_on);

  AST_SRC_EXCLUSIVE: assert property (@(negedge clk_se) disable iff (!rst_n)
    !(se_on && df_on)); // R8
endmodule

// File: rtl/cdiv_divider.sv
`timescale 1ns/1ps
module cdiv_divider
  import cdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ratio_code_t code_in,
  output logic        div_clk,
  output logic        low_next
);
  logic [SYNC_STAGES-1:0][SEL_W-1:0] code_pipe;
  ratio_code_t code_sync, cnt_q, ratio_q, nxt_cnt, nxt_ratio;
  logic wrap, q_p, q_n, q_p_d, pass, odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_pipe <= '1;
    else        code_pipe <= {code_pipe[SYNC_STAGES-2:0], code_in};
  end
  assign code_sync = code_pipe[SYNC_STAGES-1];

  // a new ratio is adopted only when the count wraps
  always_comb begin
    wrap      = (cnt_q == ratio_q);
    nxt_ratio = wrap ? code_sync : ratio_q;
    nxt_cnt   = wrap ? '0 : cnt_q + 1'b1;
    q_p_d     = ({1'b0, nxt_cnt} < high_span(nxt_ratio));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      ratio_q <= '1;
      q_p     <= 1'b0;
    end else begin
      cnt_q   <= nxt_cnt;
      ratio_q <= nxt_ratio;
      q_p     <= q_p_d;
    end
  end

  // half-cycle extension used for odd ratios
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b0;
    else        q_n <= q_p;
  end

  assign pass     = (ratio_q == '0);
  assign odd      = !ratio_q[0] && !pass;
  assign div_clk  = pass ? clk : (q_p | (odd & q_n));
  assign low_next = pass | ~q_p;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_q); // R2
  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> ($past(cnt_q) == $past(ratio_q))); // R8
endmodule

// File: rtl/cdiv_out_gate.sv
`timescale 1ns/1ps
module cdiv_out_gate #(
  parameter int NUM_OUT     = 4,
  parameter int SOLO_CNT    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_clk,
  input  logic               low_next,
  input  logic               oe_solo,
  input  logic               oe_rest,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe
);
  localparam int GRP = 2;
  logic [SYNC_STAGES-1:0][GRP-1:0] oe_pipe;
  logic [GRP-1:0] oe_sync, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_pipe <= '1;
    else        oe_pipe <= {oe_pipe[SYNC_STAGES-2:0], {oe_rest, oe_solo}};
  end
  assign oe_sync = oe_pipe[SYNC_STAGES-1];

  // enables move only on a falling edge after which the divided clock stays low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (low_next) en_q <= oe_sync;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam int G = (k < SOLO_CNT) ? 0 : 1;
    assign clk_out[k] = div_clk & en_q[G];
    assign clk_oe[k]  = en_q[G];
  end
endmodule

// File: rtl/clk_div_fanout.sv
`timescale 1ns/1ps
module clk_div_fanout
  import cdiv_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SOLO_CNT    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_se,
  input  logic               clk_diff,
  input  logic               rst_n,
  input  logic               src_sel,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               oe_solo,
  input  logic               oe_rest,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe
);
  logic clk_mux, div_clk, low_next;

  cdiv_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_se(clk_se), .clk_diff(clk_diff), .rst_n(rst_n),
    .use_diff(src_sel), .clk_sel(clk_mux));

  cdiv_divider #(.SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk(clk_mux), .rst_n(rst_n), .code_in(div_sel),
    .div_clk(div_clk), .low_next(low_next));

  cdiv_out_gate #(.NUM_OUT(NUM_OUT), .SOLO_CNT(SOLO_CNT), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk_mux), .rst_n(rst_n), .div_clk(div_clk), .low_next(low_next),
    .oe_solo(oe_solo), .oe_rest(oe_rest), .clk_out(clk_out), .clk_oe(clk_oe));

  for (genvar k = 1; k < NUM_OUT; k++) begin : g_chk
    AST_SAME_WAVE: assert property (@(posedge clk_mux) disable iff (!rst_n)
      (clk_oe[0] && clk_oe[k]) |-> (clk_out[0] == clk_out[k])); // R7
  end
endmodule

// File: tb/clk_div_fanout_bench.sv
`timescale 1ns/1ps
module clk_div_fanout_bench;
  localparam int WIN = 576;

  logic clk_se = 1'b0, clk_diff = 1'b0, rst_n = 1'b1;
  logic src_sel = 1'b1, oe_solo = 1'b1, oe_rest = 1'b1;
  logic [1:0] div_sel = 2'b11;
  logic [3:0] clk_out, clk_oe;

  int total = 0, bad = 0;
  int rises [4];
  int highs [4];
  int mism;
  bit meas = 1'b0, track = 1'b0, done = 1'b0;
  real last0 = 0.0, last1 = 0.0, minw = 1.0e9;
  bit seen0 = 1'b0, seen1 = 1'b0;

  always #4 clk_se = ~clk_se;     // 125 MHz
  always #6 clk_diff = ~clk_diff;

  clk_div_fanout u_clk_div_fanout (
    .clk_se(clk_se), .clk_diff(clk_diff), .rst_n(rst_n), .src_sel(src_sel),
    .div_sel(div_sel), .oe_solo(oe_solo), .oe_rest(oe_rest),
    .clk_out(clk_out), .clk_oe(clk_oe));

  always @(posedge clk_out[0]) if (meas) rises[0]++;
  always @(posedge clk_out[1]) if (meas) rises[1]++;
  always @(posedge clk_out[2]) if (meas) rises[2]++;
  always @(posedge clk_out[3]) if (meas) rises[3]++;

  always @(clk_out[0]) if (track) begin
    if (seen0 && ($realtime - last0) > 0.05 && ($realtime - last0) < minw) minw = $realtime - last0;
    last0 = $realtime; seen0 = 1'b1;
  end
  always @(clk_out[1]) if (track) begin
    if (seen1 && ($realtime - last1) > 0.05 && ($realtime - last1) < minw) minw = $realtime - last1;
    last1 = $realtime; seen1 = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure();
    for (int k = 0; k < 4; k++) begin rises[k] = 0; highs[k] = 0; end
    mism = 0;
    #0.3;
    meas = 1'b1;
    for (int t = 0; t < WIN; t++) begin
      #1;
      for (int k = 0; k < 4; k++) if (clk_out[k]) highs[k]++;
      if (clk_oe == 4'b1111 && clk_out != {4{clk_out[0]}}) mism++;
    end
    meas = 1'b0;
    #0.7;
  endtask

  function automatic bit near(input int a, input int e, input int tol);
    return (a >= e - tol) && (a <= e + tol);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #50;
    check(clk_out == 4'b0, "R9 clk_out in reset", int'(clk_out), 0);
    check(clk_oe == 4'b0, "R9 clk_oe in reset", int'(clk_oe), 0);
    #9 rst_n = 1'b1;
    track = 1'b1;
    #400;
    // R10 defaults: diff source (12 ns) at /4 -> 48 ns period
    measure();
    for (int k = 0; k < 4; k++)
      check(near(rises[k], WIN / 48, 1), "R10 default rate", rises[k], WIN / 48);
    check(clk_oe == 4'b1111, "R10 default enables", int'(clk_oe), 15);

    // R1/R2/R3/R4/R7 sweep of source and ratio
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        int per;
        src_sel = s[0];
        div_sel = c[1:0];
        #400;
        measure();
        per = (s == 1 ? 12 : 8) * (c + 1);
        for (int k = 0; k < 4; k++)
          check(near(rises[k], WIN / per, 1), s == 1 ? "R1 R2 diff rate" : "R1 R2 se rate", rises[k], WIN / per);
        if (c == 0) check(near(highs[0], WIN / 2, 17), "R4 pass-through duty", highs[0], WIN / 2);
        else        check(near(highs[0], WIN / 2, 17), "R3 divided duty", highs[0], WIN / 2);
        check(mism == 0, "R7 outputs identical", mism, 0);
        check(clk_oe == 4'b1111, "R6 enabled flags", int'(clk_oe), 15);
      end
    end

    // R5/R6 enable patterns at clk_se /2 (16 ns)
    src_sel = 1'b0;
    div_sel = 2'b01;
    for (int p = 0; p < 4; p++) begin
      oe_solo = p[0];
      oe_rest = p[1];
      #400;
      measure();
      for (int k = 0; k < 4; k++) begin
        bit on;
        on = (k == 0) ? p[0] : p[1];
        if (on) begin
          check(near(rises[k], WIN / 16, 1), "R5 enabled output runs", rises[k], WIN / 16);
          check(clk_oe[k] == 1'b1, "R6 flag on", int'(clk_oe[k]), 1);
        end else begin
          check(rises[k] == 0 && highs[k] == 0, "R6 disabled output low", highs[k], 0);
          check(clk_oe[k] == 1'b0, "R6 flag off", int'(clk_oe[k]), 0);
        end
      end
    end

    // R8 stress: live changes of ratio, enables and source
    oe_solo = 1'b1;
    oe_rest = 1'b1;
    for (int i = 0; i < 40; i++) begin
      div_sel = div_sel + 2'd1 + i[1:0];
      #37;
    end
    for (int i = 0; i < 12; i++) begin
      src_sel = ~src_sel;
      div_sel = i[1:0];
      #150;
    end
    for (int i = 0; i < 24; i++) begin
      oe_solo = ~oe_solo;
      if (i % 3 == 0) oe_rest = ~oe_rest;
      div_sel = i[2:1];
      #29;
    end
    #300;
    track = 1'b0;
    check(minw >= 3.9, "R8 shortest pulse x10", int'(minw * 10.0), 40);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule